// File: doc/BRIEF.md
# Two-Wire Bus Start-Pattern Classifier

This block watches the two lines, A and B, of a self-clocked serial bus and works out which control pattern opens each transaction. Both lines are first brought into the local clock domain by a synchroniser. Edges are then found by comparing consecutive synchronised samples. The block arms when it sees A low and B high in the same sample. While armed, it counts the falling edges on B. When A rises, it classifies the count.

There are five possible outcomes: a plain start, a start whose payload carries a CRC, a bus-occupancy marker, a bus reset, and a framing error. Each outcome produces a one-clock strobe. The two start outcomes also raise a level flag, which tells the downstream byte receiver that data bytes follow. The block keeps that flag high, and ignores the lines, until the receiver releases the bus. The release comes after the receiver has seen an end pattern or a fault. After every other outcome the block goes straight back to searching for a new pattern.

Top module: `start_pattern_classifier`

## Requirements
- R1: While reset is asserted, and in the first cycles after it is released, all five strobes and the data-follows flag are low.
- R2: The block arms only on a synchronised sample in which A is low and B is high. B falling edges that occur before arming are not counted.
- R3: When A rises with B high after exactly 4 counted B falls, the block pulses the start strobe and raises the data-follows flag.
- R4: When A rises with B high after exactly 6 counted B falls, the block pulses the start-with-CRC strobe and raises the data-follows flag.
- R5: When A rises with B high after exactly 8 counted B falls, the block pulses the occupancy strobe and leaves the data-follows flag low.
- R6: When A rises with B high after 14 or more counted B falls, the block pulses the bus-reset strobe and leaves the data-follows flag low.
- R7: The fall counter saturates at its maximum of 15. Any longer run of B falls, for example 31, is still reported as a bus reset.
- R8: Any other count (0, 1, 5, 7, 9, 13 and so on) at the rising edge of A, with B high, produces a framing-error strobe.
- R9: If B is low when A rises, the block reports a framing error whatever the count. This includes the case where B falls in the same sample as A rises.
- R10: Each outcome is a strobe exactly one clock wide, and at most one strobe is high in any cycle.
- R11: The data-follows flag stays high until the release input is sampled high. It drops in the cycle after that sample. While the flag is high, any pattern on the lines produces no strobe.
- R12: After an occupancy, bus-reset or framing-error outcome, the block searches again without needing a release. The next pattern is classified normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_a_i | input | 1 | Bus line A, asynchronous to clk_i |
| line_b_i | input | 1 | Bus line B, asynchronous to clk_i |
| rx_release_i | input | 1 | Downstream receiver gives the bus back (ends the data phase) |
| start_o | output | 1 | One-cycle strobe: plain start detected |
| start_crc_o | output | 1 | One-cycle strobe: start with CRC detected |
| occupancy_o | output | 1 | One-cycle strobe: bus-occupancy pattern detected |
| bus_reset_o | output | 1 | One-cycle strobe: reset pattern detected |
| frame_err_o | output | 1 | One-cycle strobe: malformed pattern |
| data_follows_o | output | 1 | High from a start outcome until release |

## Verification
The counting path and the classifying path can act on the same synchronised sample: B falls in the same sample in which A rises. The bench provokes this case by driving both lines in one step, three falls into a pattern. If the fall were counted, the total would reach the plain-start count of four. The only acceptable result is a single framing-error strobe with the data-follows flag low, because B is low at the moment of classification. A second overlap is also exercised: a complete pattern arriving while the data-follows flag is held. It must produce no strobe until the release is given.

// File: rtl/spc_pkg.sv
package spc_pkg;

  typedef enum logic [1:0] {
    ST_HUNT,
    ST_ARMED,
    ST_HOLD
  } spc_state_e;

  typedef enum logic [2:0] {
    OC_NONE,
    OC_START,
    OC_START_CRC,
    OC_OCCUPY,
    OC_BUS_RESET,
    OC_FRAME_ERR
  } spc_outcome_e;

  typedef struct packed {
    logic start;
    logic start_crc;
    logic occupy;
    logic bus_reset;
    logic frame_err;
  } spc_strobe_t;

  // Outcome decision at the rising edge of line A.
  function automatic spc_outcome_e classify(
    input int unsigned edges,
    input logic        b_high,
    input int unsigned n_start,
    input int unsigned n_crc,
    input int unsigned n_occ,
    input int unsigned n_rst
  );
    if (!b_high)             return OC_FRAME_ERR;
    if (edges == n_start)    return OC_START;
    if (edges == n_crc)      return OC_START_CRC;
    if (edges == n_occ)      return OC_OCCUPY;
    if (edges >= n_rst)      return OC_BUS_RESET;
    return OC_FRAME_ERR;
  endfunction

  function automatic logic has_payload(input spc_outcome_e oc);
    return (oc == OC_START) || (oc == OC_START_CRC);
  endfunction

  function automatic spc_strobe_t to_strobe(input spc_outcome_e oc);
    spc_strobe_t s;
    s = '0;
    case (oc)
      OC_START:     s.start     = 1'b1;
      OC_START_CRC: s.start_crc = 1'b1;
      OC_OCCUPY:    s.occupy    = 1'b1;
      OC_BUS_RESET: s.bus_reset = 1'b1;
      OC_FRAME_ERR: s.frame_err = 1'b1;
      default:      s           = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/spc_sync.sv
module spc_sync #(
  parameter int unsigned          WIDTH   = 2,
  parameter int unsigned          STAGES  = 2,
  parameter logic [WIDTH-1:0]     RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  generate
    if (STAGES <= 1) begin : g_single
      logic [WIDTH-1:0] stage_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= RST_VAL;
        else         stage_q <= d_i;
      end
      assign q_o = stage_q;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] chain_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
      assign q_o = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/spc_edge_det.sv
module spc_edge_det #(
  parameter int unsigned      WIDTH   = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);

  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= lvl_i;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign rise_o[i] = ~prev_q[i] &  lvl_i[i];
    assign fall_o[i] =  prev_q[i] & ~lvl_i[i];
  end

endmodule

// File: rtl/spc_classifier.sv
module spc_classifier
  import spc_pkg::*;
#(
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned N_START = 4,
  parameter int unsigned N_CRC   = 6,
  parameter int unsigned N_OCC   = 8,
  parameter int unsigned N_RST   = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             a_lvl_i,
  input  logic             b_lvl_i,
  input  logic             a_rise_i,
  input  logic             b_fall_i,
  input  logic             release_i,
  output spc_strobe_t      strobe_o,
  output logic             data_follows_o,
  output logic             armed_o,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  spc_state_e       state_q, state_d;
  logic [CNT_W-1:0] count_q, count_d;
  spc_outcome_e     outcome;
  spc_strobe_t      strobe_q;

  always_comb begin
    state_d = state_q;
    count_d = count_q;
    outcome = OC_NONE;
    case (state_q)
      ST_HUNT: begin
        if (!a_lvl_i && b_lvl_i) begin
          state_d = ST_ARMED;
          count_d = '0;
        end
      end
      ST_ARMED: begin
        if (a_rise_i) begin
          outcome = classify(int'(count_q), b_lvl_i, N_START, N_CRC, N_OCC, N_RST);
          state_d = has_payload(outcome) ? ST_HOLD : ST_HUNT;
        end else if (b_fall_i) begin
          count_d = sat_inc(count_q);
        end
      end
      ST_HOLD: begin
        if (release_i) state_d = ST_HUNT;
      end
      default: state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_HUNT;
      count_q  <= '0;
      strobe_q <= '0;
    end else begin
      state_q  <= state_d;
      count_q  <= count_d;
      strobe_q <= to_strobe(outcome);
    end
  end

  assign strobe_o       = strobe_q;
  assign data_follows_o = (state_q == ST_HOLD);
  assign armed_o        = (state_q == ST_ARMED);
  assign count_o        = count_q;

endmodule

// File: rtl/start_pattern_classifier.sv
module start_pattern_classifier
  import spc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned N_START     = 4,
  parameter int unsigned N_CRC       = 6,
  parameter int unsigned N_OCC       = 8,
  parameter int unsigned N_RST       = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_a_i,
  input  logic line_b_i,
  input  logic rx_release_i,
  output logic start_o,
  output logic start_crc_o,
  output logic occupancy_o,
  output logic bus_reset_o,
  output logic frame_err_o,
  output logic data_follows_o
);

  localparam int unsigned LINES = 2;
  localparam int unsigned IDX_A = 1;
  localparam int unsigned IDX_B = 0;

  logic [LINES-1:0] lines_sync;
  logic [LINES-1:0] lines_rise;
  logic [LINES-1:0] lines_fall;
  logic             a_lvl, b_lvl, a_rise, b_fall;
  logic             armed;
  logic [CNT_W-1:0] pat_count;
  spc_strobe_t      strobe;

  spc_sync #(
    .WIDTH  (LINES),
    .STAGES (SYNC_STAGES),
    .RST_VAL('1)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({line_a_i, line_b_i}),
    .q_o   (lines_sync)
  );

  spc_edge_det #(
    .WIDTH  (LINES),
    .RST_VAL('1)
  ) i_edges (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lines_sync),
    .rise_o(lines_rise),
    .fall_o(lines_fall)
  );

  assign a_lvl  = lines_sync[IDX_A];
  assign b_lvl  = lines_sync[IDX_B];
  assign a_rise = lines_rise[IDX_A];
  assign b_fall = lines_fall[IDX_B];

  spc_classifier #(
    .CNT_W  (CNT_W),
    .N_START(N_START),
    .N_CRC  (N_CRC),
    .N_OCC  (N_OCC),
    .N_RST  (N_RST)
  ) i_classifier (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .a_lvl_i       (a_lvl),
    .b_lvl_i       (b_lvl),
    .a_rise_i      (a_rise),
    .b_fall_i      (b_fall),
    .release_i     (rx_release_i),
    .strobe_o      (strobe),
    .data_follows_o(data_follows_o),
    .armed_o       (armed),
    .count_o       (pat_count)
  );

  assign start_o     = strobe.start;
  assign start_crc_o = strobe.start_crc;
  assign occupancy_o = strobe.occupy;
  assign bus_reset_o = strobe.bus_reset;
  assign frame_err_o = strobe.frame_err;

endmodule

// File: rtl/start_pattern_classifier_chk.sv
module start_pattern_classifier_chk #(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             start_crc_i,
  input logic             occupancy_i,
  input logic             bus_reset_i,
  input logic             frame_err_i,
  input logic             follows_i,
  input logic             release_i,
  input logic             armed_i,
  input logic             a_rise_i,
  input logic             b_fall_i,
  input logic             b_lvl_i,
  input logic [CNT_W-1:0] count_i
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic any_strobe;
  assign any_strobe = start_i | start_crc_i | occupancy_i | bus_reset_i | frame_err_i;

  p_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_i, start_crc_i, occupancy_i, bus_reset_i, frame_err_i}));

  p_single_cycle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_strobe |=> !any_strobe);

  p_follow_on_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i | start_crc_i) |-> follows_i);

  p_no_follow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occupancy_i | bus_reset_i | frame_err_i) |-> !follows_i);

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (follows_i && !release_i) |=> follows_i);

  p_release_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (follows_i && release_i) |=> !follows_i);

  p_quiet_in_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    follows_i |=> (!any_strobe || !$past(follows_i)));

  p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && b_fall_i && !a_rise_i && count_i != CNT_TOP) |=> count_i == $past(count_i) + 1'b1);

  p_saturate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && b_fall_i && !a_rise_i && count_i == CNT_TOP) |=> count_i == CNT_TOP);

  p_b_low_error_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && a_rise_i && !b_lvl_i) |=> frame_err_i);

endmodule

bind start_pattern_classifier start_pattern_classifier_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_o),
  .start_crc_i(start_crc_o),
  .occupancy_i(occupancy_o),
  .bus_reset_i(bus_reset_o),
  .frame_err_i(frame_err_o),
  .follows_i  (data_follows_o),
  .release_i  (rx_release_i),
  .armed_i    (armed),
  .a_rise_i   (a_rise),
  .b_fall_i   (b_fall),
  .b_lvl_i    (b_lvl),
  .count_i    (pat_count)
);

// File: tb/test_start_pattern_classifier.sv
module test_start_pattern_classifier;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a = 1'b1;
  logic b = 1'b1;
  logic rel = 1'b0;
  logic start, start_crc, occupancy, bus_reset, frame_err, follows;

  always #4 clk = ~clk;

  start_pattern_classifier i_start_pattern_classifier (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .line_a_i      (a),
    .line_b_i      (b),
    .rx_release_i  (rel),
    .start_o       (start),
    .start_crc_o   (start_crc),
    .occupancy_o   (occupancy),
    .bus_reset_o   (bus_reset),
    .frame_err_o   (frame_err),
    .data_follows_o(follows)
  );

  int n_checks = 0;
  int n_errs = 0;
  bit done = 1'b0;
  int hits [5] = '{default: 0};

  // Outcome index: 0 start, 1 start-crc, 2 occupancy, 3 reset, 4 frame error
  always @(negedge clk) begin
    if (rst_n) begin
      if (start)     hits[0]++;
      if (start_crc) hits[1]++;
      if (occupancy) hits[2]++;
      if (bus_reset) hits[3]++;
      if (frame_err) hits[4]++;
    end
  end

  // {expected code (1..5, 0 none), B low at A rise, fall count}
  localparam int N_VEC = 15;
  localparam logic [9:0] VEC [N_VEC] = '{
    {3'd1, 1'b0, 6'd4},  {3'd2, 1'b0, 6'd6},  {3'd3, 1'b0, 6'd8},
    {3'd4, 1'b0, 6'd14}, {3'd4, 1'b0, 6'd15}, {3'd4, 1'b0, 6'd16},
    {3'd4, 1'b0, 6'd31}, {3'd5, 1'b0, 6'd0},  {3'd5, 1'b0, 6'd1},
    {3'd5, 1'b0, 6'd5},  {3'd5, 1'b0, 6'd7},  {3'd5, 1'b0, 6'd9},
    {3'd5, 1'b0, 6'd13}, {3'd5, 1'b1, 6'd4},  {3'd5, 1'b1, 6'd8}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic na, input logic nb);
    a = na;
    b = nb;
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic pattern(input int n, input bit b_low_end);
    step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    for (int i = 0; i < n; i++) begin
      step(1'b0, 1'b0);
      step(1'b0, 1'b1);
    end
    if (b_low_end) begin
      step(1'b0, 1'b0);
      step(1'b1, 1'b0);
    end else begin
      step(1'b1, 1'b1);
    end
    step(1'b1, 1'b1);
    repeat (6) @(posedge clk);
    #1;
  endtask

  task automatic expect_hits(input int snap [5], input int code, input string tag);
    for (int k = 0; k < 5; k++) begin
      int got;
      int want;
      got  = hits[k] - snap[k];
      want = (code == k + 1) ? 1 : 0;
      chk(got == want, $sformatf("%s strobe %0d count", tag, k), got, want);
    end
  endtask

  task automatic do_release();
    rel = 1'b1;
    @(posedge clk);
    #1;
    rel = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk(follows == 1'b0, "R11 flag after release", follows, 0);
  endtask

  initial begin
    int snap [5];
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk({start, start_crc, occupancy, bus_reset, frame_err, follows} == 6'b0,
        "R1 outputs in reset", {start, start_crc, occupancy, bus_reset, frame_err, follows}, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk({start, start_crc, occupancy, bus_reset, frame_err, follows} == 6'b0,
        "R1 outputs after reset", {start, start_crc, occupancy, bus_reset, frame_err, follows}, 0);

    // Table walk: R3..R9
    for (int v = 0; v < N_VEC; v++) begin
      int n;
      int code;
      bit blow;
      string tag;
      n    = int'(VEC[v][5:0]);
      blow = VEC[v][6];
      code = int'(VEC[v][9:7]);
      case (code)
        1: tag = "R3";
        2: tag = "R4";
        3: tag = "R5";
        4: tag = (n > 15) ? "R7" : "R6";
        default: tag = blow ? "R9" : "R8";
      endcase
      snap = hits;
      pattern(n, blow);
      expect_hits(snap, code, $sformatf("%s n=%0d", tag, n));
      chk(follows == ((code == 1 || code == 2) ? 1'b1 : 1'b0),
          $sformatf("%s data-follows n=%0d", tag, n), follows, (code <= 2) ? 1 : 0);
      if (follows) do_release();
    end

    // R2: B falls with A high are ignored; A low with B low does not arm
    snap = hits;
    for (int i = 0; i < 5; i++) begin
      step(1'b1, 1'b0);
      step(1'b1, 1'b1);
    end
    repeat (4) @(posedge clk);
    #1;
    expect_hits(snap, 0, "R2 idle B toggles");
    snap = hits;
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 1'b0);
      step(1'b0, 1'b1);
    end
    step(1'b1, 1'b1);
    repeat (6) @(posedge clk);
    #1;
    expect_hits(snap, 1, "R2 arm after B high");
    chk(follows == 1'b1, "R3 flag after start", follows, 1);

    // R11: pattern while held produces nothing
    snap = hits;
    pattern(8, 1'b0);
    expect_hits(snap, 0, "R11 pattern during hold");
    chk(follows == 1'b1, "R11 flag held", follows, 1);
    do_release();

    // R9: B falls in the same sample as A rises after three counted falls
    snap = hits;
    step(1'b0, 1'b1);
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b0);
      step(1'b0, 1'b1);
    end
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    repeat (6) @(posedge clk);
    #1;
    expect_hits(snap, 5, "R9 coincident edges");
    chk(follows == 1'b0, "R9 flag after error", follows, 0);

    // R12: next pattern after error classified without release
    snap = hits;
    pattern(6, 1'b0);
    expect_hits(snap, 2, "R12 after error");
    chk(follows == 1'b1, "R12 flag", follows, 1);
    do_release();

    // R12: after reset outcome, occupancy recognised directly
    snap = hits;
    pattern(20, 1'b0);
    expect_hits(snap, 4, "R12 reset outcome");
    snap = hits;
    pattern(8, 1'b0);
    expect_hits(snap, 3, "R12 after reset outcome");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog R1-timeout: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end

endmodule